// File: doc/BRIEF.md
# Manchester Bi-Phase-Level Line Encoder

This block turns a serial NRZ bit stream into a bi-phase-level line code in which every bit cell carries a transition at its centre. A one is sent as a high half-cell followed by a low half-cell, so the mid-cell edge falls. A zero is sent as low then high, so the mid-cell edge rises. The receiver can therefore recover timing from the line itself. A true line output and its exact complement are produced together. A line-enable flag stands in for the pad drivers' tri-state control.

The block runs on a single system clock at twice the bit rate. An internal half-cell phase flag selects which half of the cell is driven, so no logic uses both edges of a bit clock. The data input is taken once per cell, on the system clock edge that opens the cell, and that sampled value shapes both halves. A copy of the bit clock is forwarded on a separate output. It is high during the first half of each cell and can be gated off. The synchronous active-low reset and both control inputs are defined so that a user who needs no reset, always wants the line driven and has no use for the clock copy can simply tie them to their idle values.

Top module: `manch_enc`

## Requirements
- R1: A sampled one is sent as line_p high for the first half-cell and low for the second half-cell, so the mid-cell edge on line_p falls.
- R2: A sampled zero is sent as line_p low for the first half-cell and high for the second half-cell, so the mid-cell edge on line_p rises.
- R3: bit_in is sampled only on the system clock edge that opens a cell, and line_p shows the sampled value from that edge. A change of bit_in during the second half-cell has no effect on the line.
- R4: One bit cell lasts exactly two system clocks, and cells follow back to back. The first cell opens on the first rising edge at which rst_n is sampled high.
- R5: While rst_n is sampled low, the outputs after the edge are line_p = 0, line_n = 1, line_oe = 0 and clk_rep = 0, and the phase flag returns to the first half. A reset applied in mid-cell therefore makes the next cell start cleanly with its first half.
- R6: line_oe is 0 from the edge at which tx_off is sampled high, and 1 from the edge at which tx_off is sampled low (outside reset). The encoded data keeps running while the line is disabled.
- R7: clk_rep is 1 during the first half-cell and 0 during the second half-cell while clkrep_en is sampled high. It is 0 in both halves while clkrep_en is sampled low.
- R8: line_n is the bitwise complement of line_p in every cycle, with no cycle of skew between them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, twice the bit rate |
| rst_n | input | 1 | Synchronous active-low reset; tie high for normal use |
| bit_in | input | 1 | NRZ data, sampled at the edge opening each cell |
| tx_off | input | 1 | Active-high disable of the line outputs; tie low to keep them driven |
| clkrep_en | input | 1 | Active-high enable of the forwarded clock copy |
| line_p | output | 1 | Bi-phase-level line signal, true polarity |
| line_n | output | 1 | Bi-phase-level line signal, complement |
| line_oe | output | 1 | Line drive enable flag (1 = outputs driven) |
| clk_rep | output | 1 | Gated copy of the bit clock, high in the first half-cell |

## Verification
The bench drives a stream of ones, zeros, runs of equal bits and alternations. It checks both halves of every cell, so a swapped polarity or a missing mid-cell transition shows up as a wrong level in one half. It changes bit_in inside the second half-cell. A design that samples on every edge would then produce a wrong second half. It asserts reset in mid-cell and releases it with a zero. A phase flag that is not cleared would open with the second half and put a one on the line. It also toggles the line disable and the clock-copy enable around cell boundaries. An enable taken from the wrong edge, or a clock copy left ungated, then shows up as a mismatch in the half-cell where it occurs.

// File: rtl/manch_enc_pkg.sv
// Shared types for the Manchester line encoder.
package manch_enc_pkg;

    // Which half of the bit cell the next system clock edge produces.
    typedef enum logic {
        HALF_FIRST  = 1'b0,
        HALF_SECOND = 1'b1
    } half_t;

endpackage

// File: rtl/manch_phase_gen.sv
// Half-cell phase generator.
// Holds which half of the bit cell the next edge will produce. It toggles on
// every system clock and returns to HALF_FIRST under synchronous reset.
// Assumes: clk runs at twice the bit rate; rst_n is synchronous and active-low.
module manch_phase_gen
    import manch_enc_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    output half_t phase_q
);

    // Toggle the half-cell flag each clock; reset restarts at the first half.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= HALF_FIRST;
        end else begin
            phase_q <= (phase_q == HALF_FIRST) ? HALF_SECOND : HALF_FIRST;
        end
    end

    // R4
    phase_alternates_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (phase_q != $past(phase_q)));

endmodule

// File: rtl/manch_cell_shaper.sv
// Bit cell shaper.
// Captures bit_in at the edge that opens a cell and drives the line level:
// the sampled bit in the first half and its inverse in the second half.
// Assumes: phase_in comes from manch_phase_gen on the same clock and reset.
module manch_cell_shaper
    import manch_enc_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  half_t phase_in,
    input  logic  bit_in,
    output logic  line_q
);

    logic held_q;

    // Latch the data bit once per cell, at the opening edge only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_q <= 1'b0;
        end else if (phase_in == HALF_FIRST) begin
            held_q <= bit_in;
        end
    end

    // Drive the line level: sampled bit first, its inverse second.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_q <= 1'b0;
        end else if (phase_in == HALF_FIRST) begin
            line_q <= bit_in;
        end else begin
            line_q <= ~held_q;
        end
    end

    // R1 R2
    mid_cell_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && ($past(phase_in) == HALF_SECOND)) |-> (line_q != $past(line_q)));

    // R3
    cell_open_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && ($past(phase_in) == HALF_FIRST)) |-> (line_q == $past(bit_in)));

endmodule

// File: rtl/manch_out_stage.sv
// Output stage.
// Produces the true and complementary line outputs from one register, the
// registered line-enable flag and the gated copy of the bit clock.
// Assumes: line_in and phase_in come from the same clock domain and reset.
module manch_out_stage
    import manch_enc_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  half_t phase_in,
    input  logic  line_in,
    input  logic  tx_off,
    input  logic  clkrep_en,
    output logic  line_p,
    output logic  line_n,
    output logic  line_oe,
    output logic  clk_rep
);

    logic oe_q;
    logic rep_q;

    // Register the line enable so it changes on the same edge as the data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            oe_q <= 1'b0;
        end else begin
            oe_q <= ~tx_off;
        end
    end

    // Raise the clock copy for the first half-cell when it is enabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rep_q <= 1'b0;
        end else begin
            rep_q <= clkrep_en && (phase_in == HALF_FIRST);
        end
    end

    // Both polarities are taken from a single register, so they carry no skew.
    always_comb begin
        line_p  = line_in;
        line_n  = ~line_in;
        line_oe = oe_q;
        clk_rep = rep_q;
    end

    // R7
    rep_first_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clk_rep |-> ($past(phase_in) == HALF_FIRST));

    // R6
    oe_follows_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(tx_off)) |-> !line_oe);

endmodule

// File: rtl/manch_enc.sv
// Manchester bi-phase-level encoder, top level.
// A one is sent as a falling mid-cell edge and a zero as a rising one, on a
// system clock at twice the bit rate. The line outputs come in both
// polarities, with a line-enable flag and a gated copy of the bit clock.
// Assumes: synchronous active-low reset; bit_in is stable at the cell-opening edge.
module manch_enc
    import manch_enc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic bit_in,
    input  logic tx_off,
    input  logic clkrep_en,
    output logic line_p,
    output logic line_n,
    output logic line_oe,
    output logic clk_rep
);

    half_t phase_q;
    logic  line_q;

    manch_phase_gen u_phase (
        .clk     (clk),
        .rst_n   (rst_n),
        .phase_q (phase_q)
    );

    manch_cell_shaper u_shaper (
        .clk      (clk),
        .rst_n    (rst_n),
        .phase_in (phase_q),
        .bit_in   (bit_in),
        .line_q   (line_q)
    );

    manch_out_stage u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .phase_in  (phase_q),
        .line_in   (line_q),
        .tx_off    (tx_off),
        .clkrep_en (clkrep_en),
        .line_p    (line_p),
        .line_n    (line_n),
        .line_oe   (line_oe),
        .clk_rep   (clk_rep)
    );

endmodule

// File: tb/manch_enc_bench.sv
module manch_enc_bench;

    logic clk = 1'b0;
    logic rst_n, bit_in, tx_off, clkrep_en;
    logic line_p, line_n, line_oe, clk_rep;
    int   n_tests = 0;
    int   n_fail  = 0;
    bit   done    = 1'b0;

    always #2.5 clk = ~clk;

    manch_enc u_manch_enc (
        .clk(clk), .rst_n(rst_n), .bit_in(bit_in), .tx_off(tx_off),
        .clkrep_en(clkrep_en), .line_p(line_p), .line_n(line_n),
        .line_oe(line_oe), .clk_rep(clk_rep)
    );

    // Each entry: {bit, tx_off, clkrep_en} for one cell.
    localparam logic [2:0] VEC [0:11] = '{
        3'b101, 3'b001, 3'b101, 3'b101, 3'b001, 3'b001,
        3'b110, 3'b010, 3'b100, 3'b000, 3'b111, 3'b001
    };

    task automatic chk(input string req, input logic act, input logic exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %b expected %b", req, act, exp);
        end
    endtask

    // Check both polarities (R8) together with the expected true level.
    task automatic chk_line(input string req, input logic exp);
        chk(req, line_p, exp);
        chk("R8 line_n complement", line_n, ~exp);
    endtask

    initial begin
        #100000;
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; bit_in = 1'b0; tx_off = 1'b0; clkrep_en = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R5 reset state
        chk_line("R5 reset line_p", 1'b0);
        chk("R5 reset line_oe", line_oe, 1'b0);
        chk("R5 reset clk_rep", clk_rep, 1'b0);

        // Vector walk: R1 R2 R4 R6 R7, first cell opens right after release.
        rst_n = 1'b1;
        for (int i = 0; i < 12; i++) begin
            bit_in = VEC[i][2]; tx_off = VEC[i][1]; clkrep_en = VEC[i][0];
            @(posedge clk); @(negedge clk);
            chk_line(VEC[i][2] ? "R1 first half" : "R2 first half", VEC[i][2]);
            chk("R6 line_oe", line_oe, ~VEC[i][1]);
            chk("R7 clk_rep first half", clk_rep, VEC[i][0]);
            @(posedge clk); @(negedge clk);
            chk_line(VEC[i][2] ? "R1 second half" : "R2 second half", ~VEC[i][2]);
            chk("R4 R6 line_oe held", line_oe, ~VEC[i][1]);
            chk("R7 clk_rep second half", clk_rep, 1'b0);
        end

        // R3: a change of bit_in during the second half-cell is ignored.
        tx_off = 1'b0; clkrep_en = 1'b1; bit_in = 1'b1;
        @(posedge clk); @(negedge clk);
        chk_line("R3 sampled one", 1'b1);
        bit_in = 1'b0;
        @(posedge clk); @(negedge clk);
        chk_line("R3 late change ignored", 1'b0);

        // R5: reset in mid-cell, then a fresh cell that starts with its first half.
        bit_in = 1'b1;
        @(posedge clk); @(negedge clk);
        chk_line("R1 before reset", 1'b1);
        rst_n = 1'b0;
        @(posedge clk); @(negedge clk);
        chk_line("R5 mid-cell reset line_p", 1'b0);
        chk("R5 mid-cell reset line_oe", line_oe, 1'b0);
        chk("R5 mid-cell reset clk_rep", clk_rep, 1'b0);
        rst_n = 1'b1; bit_in = 1'b0;
        @(posedge clk); @(negedge clk);
        chk_line("R5 R4 phase restart first half", 1'b0);
        chk("R5 R7 clk_rep restart", clk_rep, 1'b1);
        chk("R5 R6 line_oe restart", line_oe, 1'b1);
        @(posedge clk); @(negedge clk);
        chk_line("R5 R2 restart second half", 1'b1);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule